// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to sixteen peripheral request lines and turns them into one prioritized request for the processor. Each line first passes through a two-flop synchronizer. Each line also has its own byte-wide control register, which sets a 3-bit request level, an enable, level-sensitive or edge-sensitive capture, and the active polarity. The block compares the levels of the pending sources against a programmable threshold. It then drives the highest qualifying level, as a 3-bit code, to the processor. A master enable in a general control register blocks every request.

When the processor acknowledges, a four-state handshake machine answers with an 8-bit vector. The vector is a programmable base plus the 4-bit code of the winning source. Source codes also fix the priority order, so among sources at the presented level the higher code wins. Code 11 has no source behind it. The block returns that code when an acknowledge finds nothing pending.

The handshake machine has four states:

- `ST_IDLE` waits for `iack_req`.
- `ST_LATCH` freezes the winner into the vector register.
- `ST_PRESENT` drives `vec_valid` for one cycle.
- `ST_HOLD` waits for the acknowledge to be released.

Its transitions are:

- IDLE→LATCH when the acknowledge is seen.
- LATCH→PRESENT, always.
- PRESENT→HOLD while the acknowledge is still high, or PRESENT→IDLE once it has dropped.
- HOLD→IDLE on release.

Top module: `pvic_top`

## Requirements
- R1: After reset:
  - `irq_level` is 0 and `vec_valid` is 0.
  - The vector base (address 0x10) reads 0x50.
  - General control (0x11), threshold (0x12) and every source control register (0x00–0x0F) read 0.
- R2: A source whose control bit 6 is 0 is level-sensitive. Its request is active while its synchronized input equals NOT bit 7: high for polarity 0, low for polarity 1. The request drops as soon as the input returns, with nothing latched. Bit 5 of its control register reads the active state.
- R3: A source whose control bit 6 is 1 latches a request on a rising input edge (bit 7 = 0) or a falling edge (bit 7 = 1). The latched request stays active after the input returns to its idle value, and bit 5 reads 1.
- R4: Writing a control register with bit 3 set clears that source's latched edge request. Bit 3 always reads 0.
- R5: Bits 2:0 of a control register are the source's level, and bit 4 enables it. `irq_level` is the largest level among enabled, active sources whose level is strictly above the threshold register (bits 2:0 at 0x12). It is 0 if there is no such source. It follows the inputs within five clock cycles.
- R6: Bit 1 of general control (0x11) is the master enable. While it is 0, `irq_level` is 0.
- R7: On an acknowledge, `vector` = base + code. Code is the number of the highest-numbered enabled, active source whose level equals the presented level; the sum is taken modulo 256. `vec_valid` rises two cycles after `iack_req` is first sampled high.
- R8: Code 11 has no source. Its control register ignores writes and reads 0, and its input never raises a request.
- R9: An acknowledge that finds no qualifying source returns base + 11.
- R10: The read-only register at 0x13 returns the presented level in bits 2:0.
- R11: `vec_valid` is high for exactly one cycle per acknowledge, however long `iack_req` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 16 | Raw peripheral request lines, bit n is source code n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| iack_req | input | 1 | Processor interrupt acknowledge |
| irq_level | output | 3 | Presented request level, 0 = none |
| vec_valid | output | 1 | One-cycle strobe marking `vector` valid |
| vector | output | 8 | Returned interrupt vector |

## Verification
The hardest situation to reach is a tie at the top level combined with the threshold. Several sources share the presented level while others sit at or just below the threshold, so the vector must pick the highest code among equals and ignore the rest. The bench gives each source a level by a fixed formula that spreads every level across several codes. It then drives two dozen input patterns against all eight thresholds and a changing base, and acknowledges after each one. This also reaches the spurious case, where nothing clears the threshold, and the 8-bit wrap of base + code. The polarity and trigger corners are swept separately, source by source.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_PRESENT,
        ST_HOLD
    } ack_state_t;

    // register map outside the per-source window
    localparam int ADR_VBASE = 16;
    localparam int ADR_GCTL  = 17;
    localparam int ADR_THR   = 18;
    localparam int ADR_CUR   = 19;

    // control byte bit positions (shared by every source)
    localparam int CB_CLR  = 3;
    localparam int CB_EN   = 4;
    localparam int CB_ACT  = 5;
    localparam int CB_EDGE = 6;
    localparam int CB_POL  = 7;

    localparam int GC_MASTER = 1;

    localparam logic [7:0] VBASE_RESET = 8'h50;

endpackage

// File: rtl/pvic_src_cell.sv
module pvic_src_cell #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_in,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    output logic             active,
    output logic             enabled,
    output logic [LVL_W-1:0] level,
    output logic [7:0]       ctrl_rd
);
    import pvic_pkg::*;

    logic sync_a, sync_b, sync_c;
    logic pol_q, edge_q, en_q, latch_q;
    logic [LVL_W-1:0] lvl_q;
    logic hot_now, hot_prev;
    logic unused_bits;

    assign unused_bits = ^{wdata[CB_ACT], wdata[2:LVL_W-1]};

    // two-flop synchronizer plus one stage of history for edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            sync_c <= 1'b0;
        end else begin
            sync_a <= raw_in;
            sync_b <= sync_a;
            sync_c <= sync_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= 1'b0;
            edge_q <= 1'b0;
            en_q   <= 1'b0;
            lvl_q  <= '0;
        end else if (wr_en) begin
            pol_q  <= wdata[CB_POL];
            edge_q <= wdata[CB_EDGE];
            en_q   <= wdata[CB_EN];
            lvl_q  <= wdata[LVL_W-1:0];
        end
    end

    assign hot_now  = sync_b ^ pol_q;
    assign hot_prev = sync_c ^ pol_q;

    // a fresh edge wins over a clear written in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (!edge_q) begin
            latch_q <= 1'b0;
        end else if (hot_now && !hot_prev) begin
            latch_q <= 1'b1;
        end else if (wr_en && wdata[CB_CLR]) begin
            latch_q <= 1'b0;
        end
    end

    assign active  = edge_q ? latch_q : hot_now;
    assign enabled = en_q;
    assign level   = lvl_q;

    always_comb begin
        ctrl_rd = 8'h00;
        ctrl_rd[CB_POL]     = pol_q;
        ctrl_rd[CB_EDGE]    = edge_q;
        ctrl_rd[CB_ACT]     = active;
        ctrl_rd[CB_EN]      = en_q;
        ctrl_rd[LVL_W-1:0]  = lvl_q;
    end

endmodule

// File: rtl/pvic_resolve.sv
module pvic_resolve #(
    parameter int NSRC   = 16,
    parameter int LVL_W  = 3,
    parameter int CODE_W = 4
) (
    input  logic [NSRC-1:0]            req,
    input  logic [NSRC-1:0][LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]           thr,
    output logic [LVL_W-1:0]           best_lvl,
    output logic [CODE_W-1:0]          win_code,
    output logic                       found
);
    // ascending scan with >= so a higher code takes a tie
    always_comb begin
        best_lvl = '0;
        win_code = '0;
        found    = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (lvl[i] > thr) && (lvl[i] >= best_lvl)) begin
                best_lvl = lvl[i];
                win_code = CODE_W'(i);
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pvic_ack_fsm.sv
module pvic_ack_fsm #(
    parameter int VEC_W     = 8,
    parameter int CODE_W    = 4,
    parameter int SPUR_CODE = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iack_req,
    input  logic              found,
    input  logic [CODE_W-1:0] win_code,
    input  logic [VEC_W-1:0]  base,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vector
);
    import pvic_pkg::*;

    ack_state_t state_q, state_d;
    logic [CODE_W-1:0] pick;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (iack_req) state_d = ST_LATCH;
            ST_LATCH:   state_d = ST_PRESENT;
            ST_PRESENT: state_d = iack_req ? ST_HOLD : ST_IDLE;
            ST_HOLD:    if (!iack_req) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign pick = found ? win_code : CODE_W'(SPUR_CODE);

    always_ff @(posedge clk) begin
        if (!rst_n) vector <= '0;
        else if (state_q == ST_LATCH) vector <= VEC_W'(base + VEC_W'(pick));
    end

    always_comb begin
        vec_valid = (state_q == ST_PRESENT);
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
    parameter int NSRC      = 16,
    parameter int LVL_W     = 3,
    parameter int VEC_W     = 8,
    parameter int ADDR_W    = 5,
    parameter int SPUR_CODE = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              iack_req,
    output logic [LVL_W-1:0]  irq_level,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vector
);
    import pvic_pkg::*;

    localparam int CODE_W = $clog2(NSRC);

    logic [NSRC-1:0]            act_v, en_v, req_v;
    logic [NSRC-1:0][LVL_W-1:0] lvl_v;
    logic [NSRC-1:0][7:0]       ctrl_v;
    logic                       in_src_win;
    logic [CODE_W-1:0]          src_idx;
    logic [VEC_W-1:0]           vbase_q;
    logic                       gctl_master;
    logic [LVL_W-1:0]           thr_q;
    logic [LVL_W-1:0]           best_lvl;
    logic [CODE_W-1:0]          win_code;
    logic                       found;
    logic                       unused_wbits;

    assign in_src_win = (reg_addr[ADDR_W-1:CODE_W] == '0);
    assign src_idx    = reg_addr[CODE_W-1:0];

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            localparam bit IS_SPARE = (g == SPUR_CODE);
            logic c_act, c_en;
            logic [LVL_W-1:0] c_lvl;
            logic [7:0] c_rd;
            pvic_src_cell #(.LVL_W(LVL_W)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_in  (src_in[g]),
                .wr_en   (reg_we && in_src_win && (src_idx == CODE_W'(g)) && !IS_SPARE),
                .wdata   (reg_wdata),
                .active  (c_act),
                .enabled (c_en),
                .level   (c_lvl),
                .ctrl_rd (c_rd)
            );
            assign act_v[g]  = IS_SPARE ? 1'b0 : c_act;
            assign en_v[g]   = c_en;
            assign lvl_v[g]  = c_lvl;
            assign ctrl_v[g] = IS_SPARE ? 8'h00 : c_rd;
        end
    endgenerate

    // shared registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbase_q     <= VEC_W'(VBASE_RESET);
            gctl_master <= 1'b0;
            thr_q       <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(ADR_VBASE)) vbase_q     <= VEC_W'(reg_wdata);
            if (reg_addr == ADDR_W'(ADR_GCTL))  gctl_master <= reg_wdata[GC_MASTER];
            if (reg_addr == ADDR_W'(ADR_THR))   thr_q       <= reg_wdata[LVL_W-1:0];
        end
    end

    assign unused_wbits = ^{reg_wdata[7:LVL_W], reg_wdata[0]};

    assign req_v = act_v & en_v & {NSRC{gctl_master}};

    pvic_resolve #(.NSRC(NSRC), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_resolve (
        .req      (req_v),
        .lvl      (lvl_v),
        .thr      (thr_q),
        .best_lvl (best_lvl),
        .win_code (win_code),
        .found    (found)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_level <= '0;
        else        irq_level <= best_lvl;
    end

    pvic_ack_fsm #(.VEC_W(VEC_W), .CODE_W(CODE_W), .SPUR_CODE(SPUR_CODE)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .iack_req  (iack_req),
        .found     (found),
        .win_code  (win_code),
        .base      (vbase_q),
        .vec_valid (vec_valid),
        .vector    (vector)
    );

    always_comb begin
        reg_rdata = 8'h00;
        if (in_src_win) begin
            reg_rdata = ctrl_v[src_idx];
        end else begin
            unique case (reg_addr)
                ADDR_W'(ADR_VBASE): reg_rdata = 8'(vbase_q);
                ADDR_W'(ADR_GCTL):  reg_rdata[GC_MASTER] = gctl_master;
                ADDR_W'(ADR_THR):   reg_rdata[LVL_W-1:0] = thr_q;
                ADDR_W'(ADR_CUR):   reg_rdata[LVL_W-1:0] = irq_level;
                default:            reg_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master,
    input logic [LVL_W-1:0] thr,
    input logic [LVL_W-1:0] irq_level,
    input logic             vec_valid,
    input logic             iack_req
);
    assert_master_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> (irq_level == '0));

    assert_above_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_level > $past(thr)));

    assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_ack_precedes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(iack_req, 2));

endmodule

bind pvic_top pvic_checker #(.LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (gctl_master),
    .thr       (thr_q),
    .irq_level (irq_level),
    .vec_valid (vec_valid),
    .iack_req  (iack_req)
);

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        iack_req = 1'b0;
    logic [2:0]  irq_level;
    logic        vec_valid;
    logic [7:0]  vector;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pvic_top dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .iack_req(iack_req), .irq_level(irq_level), .vec_valid(vec_valid),
        .vector(vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ack(output logic [7:0] v, output int strobes);
        strobes = 0;
        v = 8'hxx;
        @(negedge clk);
        iack_req = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (vec_valid) begin strobes++; v = vector; end
        end
        iack_req = 1'b0;
        cyc(2);
    endtask

    function automatic logic [2:0] lvl_of(input int i);
        return 3'((i * 5 + 3) % 8);
    endfunction

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        int st;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 level", 32'(irq_level), 0);
        chk("R1 valid", 32'(vec_valid), 0);
        rd(5'h10, d); chk("R1 base", 32'(d), 32'h50);
        rd(5'h11, d); chk("R1 gctl", 32'(d), 0);
        rd(5'h12, d); chk("R1 thr", 32'(d), 0);
        for (int s = 0; s < 16; s++) begin
            rd(5'(s), d); chk("R1 ctrl", 32'(d), 0);
        end

        wr(5'h11, 8'h02);
        rd(5'h11, d); chk("R6 master set", 32'(d), 2);

        // Sweep: every source, both polarities, both trigger modes (R2 R3 R4 R8 R10)
        for (int s = 0; s < 16; s++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int md = 0; md < 2; md++) begin
                    logic [7:0] c;
                    logic [2:0] lv;
                    bit spare;
                    spare = (s == 11);
                    lv = 3'((s % 7) + 1);
                    c = {1'(pol), 1'(md), 1'b0, 1'b1, 1'b0, lv};
                    src_in[s] = 1'(pol);
                    cyc(5);
                    wr(5'(s), c);
                    wr(5'(s), c | 8'h08);
                    cyc(3);
                    rd(5'(s), d);
                    chk(spare ? "R8 readback" : "R4 ctrl idle", 32'(d), spare ? 0 : 32'(c));
                    chk("R5 idle level", 32'(irq_level), 0);
                    src_in[s] = ~1'(pol);
                    cyc(5);
                    rd(5'(s), d);
                    chk(md ? "R3 act bit" : "R2 act bit", 32'(d[5]), spare ? 0 : 1);
                    chk(spare ? "R8 no request" : "R5 level", 32'(irq_level), spare ? 0 : 32'(lv));
                    rd(5'h13, d);
                    chk("R10 cur level", 32'(d), spare ? 0 : 32'(lv));
                    // enable off: still active, no request (R5)
                    wr(5'(s), c & 8'hEF);
                    cyc(2);
                    chk("R5 disabled", 32'(irq_level), 0);
                    rd(5'(s), d);
                    chk("R5 act kept", 32'(d[5]), spare ? 0 : 1);
                    wr(5'(s), c);
                    src_in[s] = 1'(pol);
                    cyc(5);
                    if (md) chk("R3 latched", 32'(irq_level), spare ? 0 : 32'(lv));
                    else    chk("R2 follows", 32'(irq_level), 0);
                    wr(5'(s), c | 8'h08);
                    cyc(3);
                    chk("R4 cleared", 32'(irq_level), 0);
                    rd(5'(s), d);
                    chk("R4 act bit", 32'(d[5]), 0);
                    wr(5'(s), 8'h00);
                    src_in[s] = 1'b0;
                end
            end
        end

        // Priority sweep: patterns x thresholds x bases (R5 R7 R9)
        for (int s = 0; s < 16; s++) wr(5'(s), {5'b00010, lvl_of(s)});
        for (int k = 0; k < 24; k++) begin
            logic [15:0] pat;
            logic [7:0] base;
            pat  = 16'((k + 1) * 40503) ^ 16'(k << 3);
            base = 8'(k * 37 + 8'h50);
            src_in = pat;
            wr(5'h10, base);
            for (int t = 0; t < 8; t++) begin
                logic [2:0] best;
                int code;
                bit fnd;
                wr(5'h12, 8'(t));
                cyc(5);
                best = 0; code = 11; fnd = 0;
                for (int i = 0; i < 16; i++) begin
                    if (i != 11 && pat[i] && int'(lvl_of(i)) > t && lvl_of(i) >= best) begin
                        best = lvl_of(i); code = i; fnd = 1;
                    end
                end
                chk("R5 max level", 32'(irq_level), 32'(best));
                ack(v, st);
                chk(fnd ? "R7 vector" : "R9 spurious", 32'(v), 32'(8'(base + 8'(code))));
                chk("R11 strobes", 32'(st), 1);
            end
        end

        // Master enable off (R6) and spurious vector (R9)
        wr(5'h12, 8'h00);
        wr(5'h10, 8'h50);
        src_in = 16'hFFFF;
        cyc(5);
        chk("R6 on level", 32'(irq_level), 7);
        wr(5'h11, 8'h00);
        cyc(3);
        chk("R6 master off", 32'(irq_level), 0);
        ack(v, st);
        chk("R9 spurious off", 32'(v), 32'h5B);
        chk("R11 one strobe", 32'(st), 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule